// File: doc/BRIEF.md
# Programmable-Rate System Time Counter

This block keeps a free-running 64-bit time value for a network controller's precision time support. A control word sets a fixed-point step and a step spacing in clock cycles. The counter adds the step once every N cycles. Software trims the clock rate by rewriting the step by a small fraction. With a 16 ns cycle and a scale of 2^19, the nominal step is 0x800000, which fits inside the 24-bit step field.

Software reaches the block through a 32-bit word interface with three live words: counter low, counter high and control. Reading the low word snapshots the high half into a shadow register, and the next high-word read returns that snapshot. A 64-bit value read as two words therefore cannot be torn by a carry that lands between the two reads. Software presets the counter by writing the low word and then the high word. The two halves enter the counter together on the edge that takes the high-word write.

Top module: `time_counter`

## Requirements
- R1: After reset the counter, the control word and the read data are all zero. The counter is therefore stopped until software programs it.
- R2: Word index 2 is the control word. Bits [23:0] hold the step and bits [31:24] hold the spacing. Reading index 2 returns the last value written there.
- R3: While the spacing field is 0 the counter holds its value.
- R4: With spacing 1 the step is added on every clock edge, starting on the edge after the control write.
- R5: With spacing N>1 the step is added once every N edges. A control write that changes the spacing restarts the phase, so the first add falls on the next edge.
- R6: A control write that keeps the spacing and changes only the step takes effect from the next add. The phase is kept, and the edge of the write still adds the old step.
- R7: A read of index 0 returns the counter's low half and copies its high half into a shadow. A read of index 1 returns the shadow, so a low-then-high pair gives one coherent 64-bit value.
- R8: A write to index 0 only holds a pending low half and leaves the counter unchanged. A write to index 1 loads {written word, pending low half} into the counter on that same edge.
- R9: The counter wraps modulo 2^64.
- R10: Read data appears on the edge that samples the read strobe and then holds until the next read. Index 3 reads zero.
- R11: On a preset edge the loaded value wins over any step due on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_idx | input | 2 | Word index: 0 low, 1 high, 2 control, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Read data is due one edge after the strobe. A preset is visible in the counter on the edge of the high-word write. After a control write, the first add lands on the following edge when spacing is 1 or the spacing has changed. The bench drives strobes on falling edges and keeps a behavioural model that advances on each rising edge. It compares read data against that model on every falling edge. Directed checks also read back worked values such as 0x10 and then 0x20 under spacing 3, and the low-half wrap to zero. Each of these reads is scheduled so that the rising edge it depends on has already passed.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_DATA_W = 32;
  localparam int TC_INC_W  = 24;
  localparam int TC_PER_W  = 8;
  localparam int TC_CNT_W  = 64;

  typedef enum logic [1:0] {
    TC_LO   = 2'd0,
    TC_HI   = 2'd1,
    TC_CTRL = 2'd2,
    TC_NONE = 2'd3
  } tc_reg_e;

  function automatic tc_reg_e tc_decode(input logic [1:0] idx);
    return tc_reg_e'(idx);
  endfunction
endpackage

// File: rtl/tc_tick_gen.sv
module tc_tick_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             tick
);
  logic [PER_W-1:0] phase;

  function automatic logic [PER_W-1:0] next_phase(input logic [PER_W-1:0] ph,
                                                  input logic [PER_W-1:0] per);
    if (per == '0)      return '0;
    else if (ph == '0)  return per - PER_W'(1);
    else                return ph - PER_W'(1);
  endfunction

  assign tick = (period != '0) && (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else              phase <= next_phase(phase, period);
  end
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [INC_W-1:0] inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  localparam int PAD_W = CNT_W - INC_W;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [INC_W-1:0] step);
    return c + {{PAD_W{1'b0}}, step};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= advance(cnt, inc);
  end
endmodule

// File: rtl/tc_regif.sv
module tc_regif
  import tc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int INC_W  = 24,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [INC_W-1:0]  ctrl_inc,
  output logic [PER_W-1:0]  ctrl_per,
  output logic              period_restart,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              lo_read,
  output logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] pend_lo,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = CNT_W - DATA_W;

  tc_reg_e          sel;
  logic [DATA_W-1:0] ctrl;

  assign sel            = tc_decode(idx);
  assign ctrl_inc       = ctrl[INC_W-1:0];
  assign ctrl_per       = ctrl[INC_W +: PER_W];
  assign load           = wr && (sel == TC_HI);
  assign load_val       = {wdata[HI_W-1:0], pend_lo};
  assign lo_read        = rd && (sel == TC_LO);
  assign period_restart = wr && (sel == TC_CTRL) && (wdata[INC_W +: PER_W] != ctrl_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      pend_lo <= '0;
      shadow  <= '0;
      rdata   <= '0;
    end else begin
      if (wr && sel == TC_LO)   pend_lo <= wdata;
      if (wr && sel == TC_CTRL) ctrl    <= wdata;
      if (rd) begin
        unique case (sel)
          TC_LO: begin
            rdata  <= cnt[DATA_W-1:0];
            shadow <= cnt[CNT_W-1:DATA_W];
          end
          TC_HI:   rdata <= shadow;
          TC_CTRL: rdata <= ctrl;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/time_counter.sv
module time_counter
  import tc_pkg::*;
#(
  parameter int DATA_W = TC_DATA_W,
  parameter int INC_W  = TC_INC_W,
  parameter int PER_W  = TC_PER_W,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [INC_W-1:0]  inc;
  logic [PER_W-1:0]  per;
  logic              period_restart;
  logic              preset_load;
  logic [CNT_W-1:0]  preset_val;
  logic              lo_read;
  logic [DATA_W-1:0] shadow;
  logic [DATA_W-1:0] pend_lo;
  logic              tick_fire;
  logic [CNT_W-1:0]  cnt;

  tc_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INC_W(INC_W), .PER_W(PER_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .idx(reg_idx),
    .wdata(reg_wdata), .cnt(cnt), .ctrl_inc(inc), .ctrl_per(per),
    .period_restart(period_restart), .load(preset_load), .load_val(preset_val),
    .lo_read(lo_read), .shadow(shadow), .pend_lo(pend_lo), .rdata(reg_rdata)
  );

  tc_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(per), .restart(period_restart), .tick(tick_fire)
  );

  tc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_fire), .inc(inc),
    .load(preset_load), .load_val(preset_val), .cnt(cnt)
  );
endmodule

// File: rtl/time_counter_chk.sv
module time_counter_chk #(
  parameter int DATA_W = 32,
  parameter int INC_W  = 24,
  parameter int PER_W  = 8,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic [CNT_W-1:0]  cnt,
  input logic [INC_W-1:0]  inc,
  input logic [PER_W-1:0]  per,
  input logic              tick_fire,
  input logic              preset_load,
  input logic              lo_read,
  input logic [DATA_W-1:0] shadow,
  input logic [DATA_W-1:0] pend_lo,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] inc_ext;
  assign inc_ext = {{(CNT_W-INC_W){1'b0}}, inc};

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (per == '0) |-> !tick_fire); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_fire && !preset_load) |=> $stable(cnt)); // R3
  AST_TICK_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_fire && !preset_load) |=> cnt == $past(cnt) + $past(inc_ext)); // R4
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_fire && $past(tick_fire) && $stable(per)) |-> per == PER_W'(1)); // R5
  AST_SHADOW_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> shadow == $past(cnt[CNT_W-1:DATA_W])); // R7
  AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> cnt == {$past(wdata), $past(pend_lo)}); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R10
endmodule

bind time_counter time_counter_chk #(
  .DATA_W(DATA_W), .INC_W(INC_W), .PER_W(PER_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(reg_rd), .cnt(cnt), .inc(inc), .per(per),
  .tick_fire(tick_fire), .preset_load(preset_load), .lo_read(lo_read),
  .shadow(shadow), .pend_lo(pend_lo), .wdata(reg_wdata), .rdata(reg_rdata)
);

// File: tb/tb_time_counter.sv
`timescale 1ns/1ps
module tb_time_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  longint unsigned m_cnt;
  logic [31:0]     m_ctrl, m_pend, m_shadow, m_rdata;
  int              m_phase;

  time_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_pend = 0; m_shadow = 0; m_rdata = 0; m_phase = 0;
    end else begin
      int  per;
      bit  step;
      longint unsigned old_cnt;
      per  = int'(m_ctrl[31:24]);
      step = (per != 0) && (m_phase == 0);
      old_cnt = m_cnt;
      if (reg_wr && reg_idx == 2'd1) m_cnt = {reg_wdata, m_pend};
      else if (step)                 m_cnt = m_cnt + longint'(m_ctrl[23:0]);
      if (reg_wr && reg_idx == 2'd2 && int'(reg_wdata[31:24]) != per) m_phase = 0;
      else if (per == 0)   m_phase = 0;
      else if (m_phase == 0) m_phase = per - 1;
      else                 m_phase = m_phase - 1;
      if (reg_rd) begin
        case (reg_idx)
          2'd0: begin m_rdata = old_cnt[31:0]; m_shadow = old_cnt[63:32]; end
          2'd1: m_rdata = m_shadow;
          2'd2: m_rdata = m_ctrl;
          default: m_rdata = 0;
        endcase
      end
      if (reg_wr && reg_idx == 2'd0) m_pend = reg_wdata;
      if (reg_wr && reg_idx == 2'd2) m_ctrl = reg_wdata;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) chk(reg_rdata, m_rdata, cur_req);

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx);
    reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10: reset state, index 3 reads zero
    cur_req = "R1";
    chk(reg_rdata, 32'h0, "R1 rdata after reset");
    rd(2'd0); chk(reg_rdata, 32'h0, "R1 low");
    rd(2'd1); chk(reg_rdata, 32'h0, "R1 high");
    rd(2'd2); chk(reg_rdata, 32'h0, "R1 ctrl");
    cur_req = "R10";
    rd(2'd3); chk(reg_rdata, 32'h0, "R10 index 3");

    // R8 / R3: low write held, counter stopped
    cur_req = "R8";
    wr(2'd0, 32'h0000_1234);
    rd(2'd0); chk(reg_rdata, 32'h0, "R8 low write held");
    wr(2'd1, 32'hFF80_0000);
    rd(2'd0); chk(reg_rdata, 32'h0000_1234, "R8 preset low");
    rd(2'd1); chk(reg_rdata, 32'hFF80_0000, "R8 preset high");
    cur_req = "R3";
    idle(5);
    rd(2'd0); chk(reg_rdata, 32'h0000_1234, "R3 stopped holds");

    // R2 / R4: spacing 1, nominal step
    cur_req = "R2";
    wr(2'd2, 32'h0180_0000);
    rd(2'd2); chk(reg_rdata, 32'h0180_0000, "R2 ctrl readback");
    cur_req = "R4";
    rd(2'd0); a = reg_rdata;
    rd(2'd0); chk(reg_rdata - a, 32'h0080_0000, "R4 step per cycle");

    // R5: spacing 3, step 0x10
    cur_req = "R5";
    wr(2'd2, 32'h0300_0010);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    idle(4);
    rd(2'd0); chk(reg_rdata, 32'h10, "R5 first add");
    rd(2'd0); chk(reg_rdata, 32'h20, "R5 second add");
    rd(2'd0); chk(reg_rdata, 32'h20, "R5 no add between");

    // R6: step rewrite, same spacing
    cur_req = "R6";
    wr(2'd2, 32'h0100_0005);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    rd(2'd0); chk(reg_rdata, 32'd0, "R6 after preset");
    rd(2'd0); chk(reg_rdata, 32'd5, "R6 old step");
    wr(2'd2, 32'h0100_0007);
    rd(2'd0); chk(reg_rdata, 32'd15, "R6 write edge uses old step");
    rd(2'd0); chk(reg_rdata, 32'd22, "R6 new step");

    // R9 / R11: wrap and preset priority
    cur_req = "R9";
    wr(2'd2, 32'h0100_0001);
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0); chk(reg_rdata, 32'hFFFF_FFFE, "R11 preset beats step");
    rd(2'd1); chk(reg_rdata, 32'hFFFF_FFFF, "R9 high before wrap");
    rd(2'd0); chk(reg_rdata, 32'h0, "R9 low after wrap");
    rd(2'd1); chk(reg_rdata, 32'h0, "R9 high after wrap");

    // R7: carry between the two reads
    cur_req = "R7";
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_0005);
    rd(2'd0); chk(reg_rdata, 32'hFFFF_FFFF, "R7 low");
    rd(2'd1); chk(reg_rdata, 32'h5, "R7 shadowed high");
    rd(2'd0); chk(reg_rdata, 32'h1, "R7 later low");
    rd(2'd1); chk(reg_rdata, 32'h6, "R7 later high");

    // R10: read data holds
    cur_req = "R10";
    rd(2'd2);
    idle(3);
    chk(reg_rdata, 32'h0100_0001, "R10 read data holds");

    idle(2);
    report();
  end
endmodule